// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a small processor subsystem. Software sets it up through one 32-bit control word: a tick-source select, an enable and an action mode. An unsigned timeout counter then advances by one on each pulse of the selected tick line. If software does not rewrite the control word before the counter wraps past its all-ones value, the block fires its action. In interrupt mode the action is a one-cycle interrupt pulse. In reset mode it is a one-cycle system-reset request.

Every control write must carry the key value 0x47 in bits 15:8. A keyed write loads the settings and also restarts the counter, which is how software "kicks" the watchdog. A write with any other key leaves the settings alone and fires the configured action at once.

Two sticky status bits record why the last action happened. They survive the system reset that the watchdog itself can cause, and only the external (power-on) reset clears them. The eight tick inputs come from a shared prescaler. Line i is expected to pulse at the division ratio 2, 4, 8, 64, 128, 1024, 2048 or 4096 for i = 0 to 7.

Top module: `wdg_guard`

## Requirements
- R1: After the external reset `ext_rst_n` is released, `rd_data` reads 0 and both `irq_o` and `rst_req_o` are low.
- R2: A write with bits 15:8 equal to 0x47 loads bits 4:0 into the control word. The bit positions are select in 2:0, enable in 3 and mode in 4. Readback returns them in the same positions. Bits 15:8 and 31:7 always read 0, whatever was written there.
- R3: A keyed write restarts the timeout counter at 0. After a kick, a full 2^CNT_W further selected ticks are needed before the action fires.
- R4: The counter advances only on a pulse of `tick_i[select]` while enable is 1. Pulses on other tick lines, or any pulse while enable is 0, never lead to an action.
- R5: With mode 0, the 2^CNT_W-th selected tick since the last kick raises `irq_o` for exactly one cycle, starting the cycle after that tick is sampled. `rst_req_o` stays low.
- R6: With mode 1, the same overflow raises `rst_req_o` for exactly one cycle and `irq_o` stays low.
- R7: A write whose bits 15:8 differ from 0x47 fires the configured action in the next cycle. This happens even when enable is 0. The write changes no setting and does not restart the counter. It sets status bit 5 (cause) and bit 6 (key failure) to 1.
- R8: A timeout action sets bit 5 to 1 and clears bit 6 to 0.
- R9: A system reset (`sys_rst_n` low) clears bits 4:0 and the counter but keeps bits 6:5. An external reset clears bits 6:5 as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External/power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, clears settings and counter only |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Write data: key in 15:8, settings in 4:0 |
| rd_data | output | 32 | Control and status readback |
| tick_i | input | 8 | Prescaler tick pulses, one line per division ratio |
| irq_o | output | 1 | One-cycle timeout interrupt pulse |
| rst_req_o | output | 1 | One-cycle system-reset request pulse |

## Verification
The hardest behaviour to observe from the ports is that a key-failure write does not restart the counter. The counter is invisible, and the same write also fires an action.

To reach it, the stimulus splits one timeout window around the bad write. It issues ten selected ticks before the bad write and then counts the ticks after it. The next action must come after exactly six more ticks, not sixteen. The bench is built with a 4-bit counter, so every tick select, both modes and the flag transitions can be swept with windows of only 16 ticks.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // settings field of the control word, bit 4 down to bit 0
  typedef struct packed {
    logic       mode;  // 1: reset request, 0: interrupt
    logic       en;
    logic [2:0] sel;
  } wdg_cfg_t;

  localparam int unsigned KEY_LSB = 8;
  localparam int unsigned KEY_W   = 8;

  function automatic logic key_match(input logic [31:0] word, input logic [KEY_W-1:0] key);
    return word[KEY_LSB +: KEY_W] == key;
  endfunction

  function automatic logic [31:0] pack_status(input wdg_cfg_t cfg, input logic cause,
                                              input logic keyfail);
    return {25'd0, keyfail, cause, cfg};
  endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
#(
  parameter logic [7:0] KEY = 8'h47
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output wdg_cfg_t    cfg_o,
  output logic        good_wr_o,
  output logic        bad_wr_o
);
  wdg_cfg_t cfg_q;
  logic     key_ok;
  logic     unused_bits;

  assign key_ok      = key_match(wr_data, KEY);
  assign good_wr_o   = wr_en & key_ok;
  assign bad_wr_o    = wr_en & ~key_ok;
  assign unused_bits = ^{wr_data[31:16], wr_data[7:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (good_wr_o) cfg_q <= wdg_cfg_t'(wr_data[4:0]);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_TICK = 8,
  localparam int unsigned SEL_W   = $clog2(NUM_TICK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_TICK-1:0] tick_vec,
  input  logic                kick,
  output logic                ovf_o,
  output logic [CNT_W-1:0]    cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step  = en & tick_vec[sel];
  // a kick in the same cycle wins over the wrap
  assign ovf_o = step & (cnt_q == {CNT_W{1'b1}}) & ~kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (kick) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdg_action.sv
module wdg_action (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic all_rst_n,
  input  logic mode,
  input  logic ovf,
  input  logic bad_wr,
  output logic irq_o,
  output logic rst_req_o,
  output logic cause_o,
  output logic keyfail_o
);
  logic fire;
  assign fire = ovf | bad_wr;

  always_ff @(posedge clk or negedge all_rst_n) begin
    if (!all_rst_n) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= fire & ~mode;
      rst_req_o <= fire & mode;
    end
  end

  // sticky cause flags, cleared by the external reset only
  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      cause_o   <= 1'b0;
      keyfail_o <= 1'b0;
    end else if (fire) begin
      cause_o   <= 1'b1;
      keyfail_o <= bad_wr;
    end
  end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter logic [7:0]  KEY   = 8'h47
) (
  input  logic        clk,
  input  logic        ext_rst_n,
  input  logic        sys_rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [7:0]  tick_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int unsigned NUM_TICK = 8;

  logic             all_rst_n;
  wdg_cfg_t         cfg_w;
  logic             good_wr_w, bad_wr_w, ovf_w, en_w;
  logic             cause_w, keyfail_w;
  logic [CNT_W-1:0] cnt_w;

  assign all_rst_n = ext_rst_n & sys_rst_n;
  assign en_w      = cfg_w.en;

  wdg_ctrl_reg #(.KEY(KEY)) u_reg (
    .clk(clk), .rst_n(all_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_o(cfg_w), .good_wr_o(good_wr_w), .bad_wr_o(bad_wr_w)
  );

  wdg_counter #(.CNT_W(CNT_W), .NUM_TICK(NUM_TICK)) u_cnt (
    .clk(clk), .rst_n(all_rst_n), .en(cfg_w.en), .sel(cfg_w.sel),
    .tick_vec(tick_i), .kick(good_wr_w), .ovf_o(ovf_w), .cnt_o(cnt_w)
  );

  wdg_action u_act (
    .clk(clk), .ext_rst_n(ext_rst_n), .all_rst_n(all_rst_n), .mode(cfg_w.mode),
    .ovf(ovf_w), .bad_wr(bad_wr_w), .irq_o(irq_o), .rst_req_o(rst_req_o),
    .cause_o(cause_w), .keyfail_o(keyfail_w)
  );

  assign rd_data = pack_status(cfg_w, cause_w, keyfail_w);
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             ext_rst_n,
  input logic             sys_rst_n,
  input logic [31:0]      rd_data,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             ovf_w,
  input logic             bad_wr_w,
  input logic             good_wr_w,
  input logic             en_w,
  input logic [CNT_W-1:0] cnt_w
);
  logic rst_all_n;
  assign rst_all_n = ext_rst_n & sys_rst_n;

  // R5
  irq_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    (ovf_w && !rd_data[4]) |=> (irq_o && !rst_req_o));

  // R5
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    (irq_o && !ovf_w && !bad_wr_w) |=> !irq_o);

  // R6
  reset_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    (ovf_w && rd_data[4]) |=> (rst_req_o && !irq_o));

  // R7
  keyfail_flags_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    bad_wr_w |=> (rd_data[6] && rd_data[5]));

  // R7
  keyfail_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    bad_wr_w |=> $stable(rd_data[4:0]));

  // R8
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    (ovf_w && !bad_wr_w) |=> (rd_data[5] && !rd_data[6]));

  // R4
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    (!en_w && !good_wr_w) |=> $stable(cnt_w));

  // R3
  kick_blocks_wrap_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    good_wr_w |-> !ovf_w);
endmodule

bind wdg_guard wdg_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .sys_rst_n(sys_rst_n), .rd_data(rd_data),
  .irq_o(irq_o), .rst_req_o(rst_req_o), .ovf_w(ovf_w), .bad_wr_w(bad_wr_w),
  .good_wr_w(good_wr_w), .en_w(en_w), .cnt_w(cnt_w)
);

// File: tb/test_wdg_guard.sv
module test_wdg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 4;
  localparam int WINDOW     = 1 << CW;

  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b0, sys_rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  tick_i = '0;
  logic [31:0] rd_data;
  logic        irq_o, rst_req_o;
  int          n_run = 0, n_fail = 0;
  logic        gi, gr;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_guard #(.CNT_W(CW), .KEY(8'h47)) i_wdg_guard (
    .clk(clk), .ext_rst_n(ext_rst_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick_i(tick_i), .irq_o(irq_o),
    .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [7:0] key, input logic [4:0] cfg);
    return {16'hA5C3, key, 3'b111, cfg};
  endfunction

  task automatic wr(input logic [31:0] d, output logic oi, output logic orq);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1; oi = irq_o; orq = rst_req_o;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tk(input int idx, output logic oi, output logic orq);
    @(negedge clk); tick_i[idx] = 1'b1;
    @(posedge clk); #1; oi = irq_o; orq = rst_req_o;
    @(negedge clk); tick_i = '0;
  endtask

  // n ticks on one line, returns OR of any pulse seen
  task automatic tks(input int idx, input int n, output logic any_i, output logic any_r);
    logic a, b;
    any_i = 1'b0; any_r = 1'b0;
    for (int k = 0; k < n; k++) begin
      tk(idx, a, b);
      any_i |= a; any_r |= b;
    end
  endtask

  task automatic ext_reset();
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ai, ar;
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 pulses", {30'd0, irq_o, rst_req_o}, 32'h0);

    // R2 sweep of all settings values with the correct key
    for (int v = 0; v < 32; v++) begin
      wr(word(8'h47, 5'(v)), ai, ar);
      chk("R2 readback", rd_data, 32'(v));
      chk("R2 no pulse on keyed write", {30'd0, ai, ar}, 32'h0);
    end

    // R4 / R5 / R8 per tick select, interrupt mode
    for (int s = 0; s < 8; s++) begin
      wr(word(8'h47, {2'b01, 3'(s)}), ai, ar);
      for (int o = 0; o < 8; o++) begin
        if (o != s) begin
          tks(o, 3, ai, ar);
          chk("R4 foreign tick ignored", {30'd0, ai, ar}, 32'h0);
        end
      end
      tks(s, WINDOW - 1, ai, ar);
      chk("R5 no early action", {30'd0, ai, ar}, 32'h0);
      tk(s, ai, ar);
      chk("R5 irq on overflow", {30'd0, ai, ar}, 32'h2);
      @(posedge clk); #1;
      chk("R5 irq one cycle", {31'd0, irq_o}, 32'h0);
      chk("R8 timeout flags", {30'd0, rd_data[6:5]}, 32'h1);
    end

    // R4 disabled counter never fires
    wr(word(8'h47, 5'b00000), ai, ar);
    tks(0, 3 * WINDOW, ai, ar);
    chk("R4 disabled", {30'd0, ai, ar}, 32'h0);

    // R3 kick restarts the window
    wr(word(8'h47, 5'b01001), ai, ar);
    tks(1, WINDOW - 1, ai, ar);
    wr(word(8'h47, 5'b01001), ai, ar);
    chk("R3 kick no action", {30'd0, ai, ar}, 32'h0);
    tks(1, WINDOW - 1, ai, ar);
    chk("R3 full window after kick", {30'd0, ai, ar}, 32'h0);
    tk(1, ai, ar);
    chk("R3 fires after full window", {30'd0, ai, ar}, 32'h2);

    // R6 reset mode
    wr(word(8'h47, 5'b11010), ai, ar);
    tks(2, WINDOW - 1, ai, ar);
    chk("R6 no early action", {30'd0, ai, ar}, 32'h0);
    tk(2, ai, ar);
    chk("R6 reset request", {30'd0, ai, ar}, 32'h1);
    @(posedge clk); #1;
    chk("R6 request one cycle", {31'd0, rst_req_o}, 32'h0);

    // R7 wrong key: action, flags, settings held, no kick
    ext_reset();
    wr(word(8'h47, 5'b01011), ai, ar);
    tks(3, 10, ai, ar);
    wr(word(8'h46, 5'b11111), ai, ar);
    chk("R7 immediate irq", {30'd0, ai, ar}, 32'h2);
    chk("R7 settings kept and flags set", rd_data, 32'h0000_006B);
    tks(3, 5, ai, ar);
    chk("R7 counter not restarted, early", {30'd0, ai, ar}, 32'h0);
    tk(3, ai, ar);
    chk("R7 counter not restarted, fires", {30'd0, ai, ar}, 32'h2);
    chk("R8 timeout clears key flag", {30'd0, rd_data[6:5]}, 32'h1);

    // R7 wrong key while disabled, reset mode
    wr(word(8'h47, 5'b10000), ai, ar);
    wr(word(8'h00, 5'b00000), ai, ar);
    chk("R7 disabled still fires", {30'd0, ai, ar}, 32'h1);
    chk("R7 flags", rd_data, 32'h0000_0070);

    // R9 system reset keeps flags, external reset clears
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    #1;
    chk("R9 sys reset keeps flags", rd_data, 32'h0000_0060);
    wr(word(8'h47, 5'b01100), ai, ar);
    tks(4, WINDOW - 1, ai, ar);
    chk("R9 counter cleared by sys reset", {30'd0, ai, ar}, 32'h0);
    ext_reset();
    #1;
    chk("R9 ext reset clears all", rd_data, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule